// File: doc/BRIEF.md
# Wide-to-Narrow Register Access Splitter

This block connects a 64-bit memory-mapped host port to a bank of 16-bit registers. The host issues one read or write with a byte address and eight byte enables. The block splits that access into one 16-bit register access for each 16-bit slot of the host word that has at least one enabled byte. Slots with no enabled bytes are skipped. The slots that are visited are handled one per clock cycle, lowest slot first.

The host is held with waitrequest until all of the register accesses have completed. For a read, the 16-bit results are assembled into their lanes of the 64-bit word. Lanes that were not enabled return zero. A single readdatavalid pulse delivers the word.

The controller has three states. IDLE waits for a request. SCAN performs one register access per cycle. FINISH releases waitrequest for exactly one cycle. The transitions are as follows. IDLE goes to SCAN when a request arrives with at least one enabled slot. IDLE goes directly to FINISH when a request arrives with no enabled slot. SCAN stays in SCAN while enabled slots remain. SCAN goes to FINISH after the last slot. FINISH always returns to IDLE.

Top module: `rwb_bridge`

## Requirements
- R1: After reset, waitrequest is high, readdatavalid is low and the register write strobe is low.
- R2: Slot k covers host writedata/readdata bits [16k+15:16k] and byteenable bits [2k+1:2k]. Its register index is (host byte address >> 1) + k, and this holds for unaligned addresses as well.
- R3: In a write, every slot whose byte-enable pair is nonzero produces one register write. That write carries the slot's 16-bit lane as data and the slot's pair as the 2-bit register byte enable, with bit 0 selecting the low byte.
- R4: A slot whose byte-enable pair is zero causes no register access, so a neighbouring register keeps its value.
- R5: Enabled slots are visited in ascending slot order, one per cycle. With k enabled slots, waitrequest first reads low k+1 clock edges after the request is presented.
- R6: Waitrequest stays high while register sub-accesses are still outstanding. It is low for exactly one cycle, and that cycle accepts the transaction.
- R7: A read yields one readdatavalid pulse, one cycle long, on the cycle after acceptance. Each enabled lane of readdata holds the full 16-bit content of its register, and every other lane is zero.
- R8: An access with all byte enables zero touches no register and is accepted after one edge. As a read, it returns all zeros.
- R9: A write with only one byte enabled in a slot changes only that byte of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 16 | Host byte address |
| h_write | input | 1 | Host write request |
| h_read | input | 1 | Host read request |
| h_wdata | input | 64 | Host write data |
| h_be | input | 8 | Host byte enables |
| h_rdata | output | 64 | Host read data |
| h_rvalid | output | 1 | Read data valid pulse |
| h_wait | output | 1 | Host wait request |
| r_idx | output | 15 | Register index |
| r_wr | output | 1 | Register write strobe |
| r_wdata | output | 16 | Register write data |
| r_be | output | 2 | Register byte enables |
| r_rdata | input | 16 | Register read data (combinational from r_idx) |

## Verification
If the pending-slot mask were wrong, the error would appear as a wrong waitrequest release cycle on the very same transaction. It would also show as a register strobe with a wrong or out-of-order index, or as a skipped slot. A wrong lane select or a missed buffer clear would show up on the first readdatavalid pulse, as a lane that is swapped, stale or not zeroed. Loss of a neighbour's value would only become visible on a later read of that register. For that reason, every masked write in the test is followed by a full-width read back.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } rwb_state_e;
endpackage

// File: rtl/rwb_slot_pick.sv
module rwb_slot_pick #(
    parameter int SLOTS = 4,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0] pend,
    output logic             any,
    output logic [SW-1:0]    first,
    output logic [SLOTS-1:0] rest
);
    always_comb begin
        any   = |pend;
        first = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (pend[i]) first = SW'(i);
        end
        rest = pend & ~(SLOTS'(1) << first);
    end
endmodule

// File: rtl/rwb_lane_buf.sv
module rwb_lane_buf #(
    parameter int SLOTS = 4,
    parameter int LW    = 16,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load,
    input  logic [SW-1:0]       sel,
    input  logic [LW-1:0]       din,
    output logic [SLOTS*LW-1:0] dout
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_lane
        logic [LW-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                   lane_q <= '0;
            else if (load && (sel == SW'(g)))      lane_q <= din;
        end
        assign dout[g*LW +: LW] = lane_q;
    end
endmodule

// File: rtl/rwb_bridge.sv
module rwb_bridge #(
    parameter int HOST_DW = 64,
    parameter int REG_DW  = 16,
    parameter int ADDR_W  = 16,
    localparam int SLOTS = HOST_DW / REG_DW,
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int BPS   = REG_DW / 8,
    localparam int HBE   = HOST_DW / 8,
    localparam int IDX_W = ADDR_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  h_addr,
    input  logic               h_write,
    input  logic               h_read,
    input  logic [HOST_DW-1:0] h_wdata,
    input  logic [HBE-1:0]     h_be,
    output logic [HOST_DW-1:0] h_rdata,
    output logic               h_rvalid,
    output logic               h_wait,
    output logic [IDX_W-1:0]   r_idx,
    output logic               r_wr,
    output logic [REG_DW-1:0]  r_wdata,
    output logic [BPS-1:0]     r_be,
    input  logic [REG_DW-1:0]  r_rdata
);
    import rwb_pkg::*;

    rwb_state_e state, nxt;

    logic [IDX_W-1:0]   base_q;
    logic               op_rd_q;
    logic [HOST_DW-1:0] wdat_q;
    logic [HBE-1:0]     be_q;
    logic [SLOTS-1:0]   pend_q;
    logic [SLOTS-1:0]   slot_hit;
    logic [HOST_DW-1:0] gathered;

    logic               any_pend;
    logic [SW-1:0]      first;
    logic [SLOTS-1:0]   rest;

    wire req = h_read | h_write;

    always_comb begin
        for (int s = 0; s < SLOTS; s++) slot_hit[s] = |h_be[s*BPS +: BPS];
    end

    rwb_slot_pick #(.SLOTS(SLOTS)) u_pick (
        .pend  (pend_q),
        .any   (any_pend),
        .first (first),
        .rest  (rest)
    );

    rwb_lane_buf #(.SLOTS(SLOTS), .LW(REG_DW)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_IDLE && req),
        .load  (state == ST_SCAN && op_rd_q),
        .sel   (first),
        .din   (r_rdata),
        .dout  (gathered)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req) nxt = (|slot_hit) ? ST_SCAN : ST_FINISH;
            ST_SCAN:   if (rest == '0) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // captured request and pending slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            op_rd_q <= 1'b0;
            wdat_q  <= '0;
            be_q    <= '0;
            pend_q  <= '0;
        end else if (state == ST_IDLE && req) begin
            base_q  <= h_addr[ADDR_W-1:1];
            op_rd_q <= h_read;
            wdat_q  <= h_wdata;
            be_q    <= h_be;
            pend_q  <= slot_hit;
        end else if (state == ST_SCAN) begin
            pend_q  <= rest;
        end
    end

    // read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rdata  <= '0;
            h_rvalid <= 1'b0;
        end else begin
            h_rvalid <= (state == ST_FINISH) && op_rd_q;
            if (state == ST_FINISH && op_rd_q) h_rdata <= gathered;
        end
    end

    // outputs
    always_comb begin
        h_wait  = (state != ST_FINISH);
        r_idx   = base_q + IDX_W'(first);
        r_wr    = (state == ST_SCAN) && !op_rd_q;
        r_wdata = wdat_q[int'(first)*REG_DW +: REG_DW];
        r_be    = be_q[int'(first)*BPS +: BPS];
    end

    AST_IDX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        r_wr |-> ((r_idx - base_q) < IDX_W'(SLOTS))); // R2
    AST_SKIP_EMPTY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        r_wr |-> (r_be != '0)); // R4
    AST_HOLD_DURING_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        r_wr |-> h_wait); // R6
    AST_ACCEPT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !h_wait |=> h_wait); // R6
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |=> !h_rvalid); // R7
    AST_RVALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |-> $past(!h_wait && h_read)); // R7
endmodule

// File: tb/sim_rwb_bridge.sv
module sim_rwb_bridge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] h_addr = '0;
    logic        h_write = 1'b0, h_read = 1'b0;
    logic [63:0] h_wdata = '0;
    logic [7:0]  h_be = '0;
    logic [63:0] h_rdata;
    logic        h_rvalid, h_wait;
    logic [14:0] r_idx;
    logic        r_wr;
    logic [15:0] r_wdata;
    logic [1:0]  r_be;
    logic [15:0] r_rdata;

    logic [15:0] regs   [0:63];
    logic [15:0] shadow [0:63];
    logic [63:0] exp_q [$];
    int vectors = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rwb_bridge u0 (.*);

    // register bank model on the narrow side
    assign r_rdata = regs[r_idx[5:0]];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) regs[i] <= '0;
        end else if (r_wr) begin
            if (r_be[0]) regs[r_idx[5:0]][7:0]  <= r_wdata[7:0];
            if (r_be[1]) regs[r_idx[5:0]][15:8] <= r_wdata[15:8];
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor: pops expected read words on each readdatavalid
    always @(negedge clk) begin
        if (rst_n && h_rvalid) begin
            if (exp_q.size() == 0) check(1'b0, "R7 extra readdatavalid", 64'd1, 64'd0);
            else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check(h_rdata == e, "R7 read data", h_rdata, e);
            end
        end
    end

    task automatic host_op(input bit rd, input logic [15:0] addr, input logic [63:0] wd,
                           input logic [7:0] be, input string tag);
        int k = 0, pos = 0, cyc = 0;
        int exp_idx [4];
        logic [63:0] e = '0;
        for (int s = 0; s < 4; s++) begin
            if (be[2*s +: 2] != 2'b00) begin
                exp_idx[k] = int'(addr >> 1) + s;
                k++;
                e[16*s +: 16] = shadow[(int'(addr >> 1) + s) % 64];
            end
        end
        if (rd) exp_q.push_back(e);
        else begin
            for (int s = 0; s < 4; s++)
                for (int b = 0; b < 2; b++)
                    if (be[2*s+b]) shadow[(int'(addr >> 1) + s) % 64][8*b +: 8] = wd[16*s+8*b +: 8];
        end
        @(negedge clk);
        h_addr = addr; h_wdata = wd; h_be = be; h_read = rd; h_write = !rd;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (r_wr) begin
                if (rd || pos >= k) check(1'b0, {tag, " R4 unexpected write"}, 64'(r_idx), 64'd0);
                else begin
                    check(int'(r_idx) == exp_idx[pos], {tag, " R2 R5 index order"}, 64'(r_idx), 64'(exp_idx[pos]));
                    pos++;
                end
            end
            if (!h_wait || cyc > 20) break;
        end
        check(cyc == k + 1, {tag, " R5 R6 waitrequest release"}, 64'(cyc), 64'(k + 1));
        if (!rd) check(pos == k, {tag, " R3 writes issued"}, 64'(pos), 64'(k));
        @(negedge clk);
        h_read = 1'b0; h_write = 1'b0;
        check(h_wait == 1'b1, {tag, " R6 single accept cycle"}, 64'(h_wait), 64'd1);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        check(h_wait == 1'b1, "R1 waitrequest in reset", 64'(h_wait), 64'd1);
        check(h_rvalid == 1'b0, "R1 rvalid in reset", 64'(h_rvalid), 64'd0);
        check(r_wr == 1'b0, "R1 write strobe in reset", 64'(r_wr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(h_wait == 1'b1 && h_rvalid == 1'b0, "R1 idle after reset", 64'({h_wait, h_rvalid}), 64'b10);

        host_op(0, 16'h0000, 64'h4444_3333_2222_1111, 8'hFF, "R3 full write");
        host_op(1, 16'h0000, '0, 8'hFF, "R7 full read");
        host_op(0, 16'h0008, 64'h0000_0000_6666_5555, 8'h0F, "R3 32-bit write");
        host_op(1, 16'h0008, '0, 8'hFF, "R7 read 32-bit pair");
        host_op(0, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h03, "R4 one slot write");
        host_op(1, 16'h0000, '0, 8'hFF, "R4 neighbour kept");
        host_op(0, 16'h0000, 64'h0000_7777_0000_0000, 8'h30, "R4 slot2 only");
        host_op(1, 16'h0000, '0, 8'hFF, "R4 readback");
        host_op(0, 16'h0000, 64'hDEAD_BEEF_DEAD_BEEF, 8'h00, "R8 empty write");
        host_op(1, 16'h0000, '0, 8'h00, "R8 empty read");
        host_op(1, 16'h0000, '0, 8'hFF, "R8 nothing changed");
        host_op(1, 16'h0000, '0, 8'h0C, "R7 partial lane read");
        host_op(0, 16'h0000, 64'h0000_0000_00AB_0000, 8'h04, "R9 single byte");
        host_op(1, 16'h0000, '0, 8'hFF, "R9 readback");
        host_op(0, 16'h0002, 64'h9999_0000_0000_0000, 8'hC0, "R2 unaligned");
        host_op(1, 16'h0008, '0, 8'hFF, "R2 readback");
        host_op(0, 16'h0010, 64'hAAAA_0000_0000_BBBB, 8'hC3, "R5 scattered");
        host_op(1, 16'h0010, '0, 8'hFF, "R5 readback");
        host_op(1, 16'h0006, '0, 8'h3C, "R2 unaligned read");
        host_op(1, 16'h0010, '0, 8'h81, "R9 odd bytes read");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 missing readdatavalid", 64'(exp_q.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule